// File: doc/BRIEF.md
# Dual-Clock FIFO with Fixed-Offset Status Flags

This block is a first-in first-out buffer that links a producer and a consumer running on separate clocks. The clocks may be unrelated or the same net. The producer presents a byte and pulls the active-low write enable low. The word is stored on a rising write-clock edge unless the buffer is full. The consumer pulls the active-low read enable low, and the oldest stored word moves into a registered output on a rising read-clock edge unless the buffer is empty. The depth is a power-of-two parameter with a default of 64.

Four active-low flags report the fill level. Empty and almost-empty are produced in the read-clock domain. Full and almost-full are produced in the write-clock domain. The two partial flags switch seven words in from each end.

Each domain compares its own binary pointer with a Gray-coded copy of the other domain's pointer, brought across through two flops. A copy that lags can hold a flag asserted for longer, but it can never allow an overrun or an underrun. The reset input is active-low. It takes effect at once and is released in step with each clock.

Top module: `xclk_fifo`

## Requirements
- R1: A rising write-clock edge with wrEnN low and fullN high stores wrData. Stored words come out in the order they were written, with none lost or repeated.
- R2: A rising read-clock edge with rdEnN low and emptyN high loads the oldest stored word into rdData. On any other read-clock edge, rdData keeps its value.
- R3: While rstN is low, fullN and almostFullN are high, emptyN and almostEmptyN are low, and rdData is 0. After rstN is released, the buffer holds no words.
- R4: Once both sides have been idle for 8 cycles of each clock, fullN is low exactly when the buffer holds DEPTH words. A write attempted while fullN is low stores nothing.
- R5: Once both sides have been idle for 8 cycles of each clock, emptyN is low exactly when the buffer holds 0 words. A read attempted while emptyN is low leaves rdData unchanged and removes nothing.
- R6: Once both sides have been idle, almostEmptyN is low for a count of 0 to 7 words and high from 8 words upward.
- R7: Once both sides have been idle, almostFullN is low for a count of DEPTH-7 to DEPTH words and high below that. For the default depth this is 57 to 64 words.
- R8: The flags are never optimistic. At every write edge where the buffer holds DEPTH words, fullN is low. At every read edge where it holds 0 words, emptyN is low. The same holds for the partial flags at their thresholds.
- R9: R1 to R8 also hold when the read clock is the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, which may be the same net as wrClk |
| rstN | input | 1 | Active-low reset: asserts at once, releases in step with each clock |
| wrEnN | input | 1 | Active-low write request |
| wrData | input | DW | Word to be written |
| rdEnN | input | 1 | Active-low read request |
| rdData | output | DW | Registered output word |
| fullN | output | 1 | Low when full (write domain) |
| almostFullN | output | 1 | Low at DEPTH-7 or more words (write domain) |
| emptyN | output | 1 | Low when empty (read domain) |
| almostEmptyN | output | 1 | Low at 7 or fewer words (read domain) |

## Verification
The two functions that can fall in the same cycle are a store and a removal. With tied clocks they land on the very same edge, often right at the empty or full boundary. The bench provokes this with long runs of random traffic that keep both enables active, once with unrelated clock periods and once with tied clocks. It judges the result with a queue model that accepts an operation only when the DUT's own flag allowed it. Every output word is compared with the queue head, and each flag is held to the conservative bound on every edge and to the exact threshold once the traffic stops.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } fifoStb_t;

  localparam int DEF_DEPTH = 64;
  localparam int DEF_DW    = 8;
  localparam int DEF_NEAR  = 7;
endpackage

// File: rtl/xclk_fifo_rstsync.sv
module xclk_fifo_rstsync (
  input  logic clk,
  input  logic arstN,
  output logic syncRstN
);
  logic stage;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      stage    <= 1'b0;
      syncRstN <= 1'b0;
    end else begin
      stage    <= 1'b1;
      syncRstN <= stage;
    end
  end
endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int NEAR  = DEF_NEAR,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          rdEnN,
  output fifoStb_t      stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          rdRstN,
  output logic          fullN,
  output logic          almostFullN,
  output logic          emptyN,
  output logic          almostEmptyN
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - NEAR);
  localparam logic [PW-1:0] AE_LVL   = PW'(NEAR + 1);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic wrRstN;

  xclk_fifo_rstsync u_wrRst (.clk(wrClk), .arstN(rstN), .syncRstN(wrRstN));
  xclk_fifo_rstsync u_rdRst (.clk(rdClk), .arstN(rstN), .syncRstN(rdRstN));

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrBinNext, wrGray;
  logic [PW-1:0] rdGrayMeta, rdGraySync, rdBinSeen, wrFill;

  assign stb.wrStb = !wrEnN && fullN;
  assign wrBinNext = wrBin + PW'(stb.wrStb);
  assign rdBinSeen = gray2bin(rdGraySync);
  assign wrFill    = wrBinNext - rdBinSeen;
  assign wrAddr    = wrBin[AW-1:0];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGrayMeta  <= '0;
      rdGraySync  <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= bin2gray(wrBinNext);
      rdGrayMeta  <= rdGray;
      rdGraySync  <= rdGrayMeta;
      fullN       <= (wrFill != FULL_LVL);
      almostFullN <= (wrFill < AF_LVL);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdBinNext, rdGray;
  logic [PW-1:0] wrGrayMeta, wrGraySync, wrBinSeen, rdFill;

  assign stb.rdStb = !rdEnN && emptyN;
  assign rdBinNext = rdBin + PW'(stb.rdStb);
  assign wrBinSeen = gray2bin(wrGraySync);
  assign rdFill    = wrBinSeen - rdBinNext;
  assign rdAddr    = rdBin[AW-1:0];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin        <= '0;
      rdGray       <= '0;
      wrGrayMeta   <= '0;
      wrGraySync   <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rdBin        <= rdBinNext;
      rdGray       <= bin2gray(rdBinNext);
      wrGrayMeta   <= wrGray;
      wrGraySync   <= wrGrayMeta;
      emptyN       <= (rdFill != '0);
      almostEmptyN <= (rdFill >= AE_LVL);
    end
  end
endmodule

// File: rtl/xclk_fifo_datapath.sv
module xclk_fifo_datapath
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int DW    = DEF_DW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  fifoStb_t      stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)        rdData <= '0;
    else if (stb.rdStb) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int DW    = DEF_DW,
  parameter int NEAR  = DEF_NEAR,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic [DW-1:0] wrData,
  input  logic          rdEnN,
  output logic [DW-1:0] rdData,
  output logic          fullN,
  output logic          almostFullN,
  output logic          emptyN,
  output logic          almostEmptyN
);
  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          rdRstN;

  xclk_fifo_ctrl #(.DEPTH(DEPTH), .NEAR(NEAR)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .rdEnN(rdEnN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdRstN(rdRstN),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  xclk_fifo_datapath #(.DEPTH(DEPTH), .DW(DW)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          wrEnN,
  input logic          rdEnN,
  input logic          fullN,
  input logic          almostFullN,
  input logic          emptyN,
  input logic          almostEmptyN,
  input logic [DW-1:0] rdData,
  input logic [AW-1:0] wrAddr
);
  // R4: a write request against a full buffer does not move the write pointer
  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fullN && !wrEnN) |=> $stable(wrAddr));

  // R5: a read request against an empty buffer leaves the output alone
  p_no_underflow_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!emptyN && !rdEnN) |=> $stable(rdData));

  // R2: with no read request the output register holds
  p_hold_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    rdEnN |=> $stable(rdData));

  // R6: empty implies almost-empty
  p_aempty_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);

  // R7: full implies almost-full
  p_afull_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEnN(wrEnN), .rdEnN(rdEnN),
  .fullN(fullN), .almostFullN(almostFullN),
  .emptyN(emptyN), .almostEmptyN(almostEmptyN),
  .rdData(rdData), .wrAddr(wrAddr)
);

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/1ps
module xclk_fifo_tb;
  localparam int DEPTH = 64;
  localparam int DW    = 8;

  logic          wrClk = 1'b0;
  logic          rdFree = 1'b0;
  logic          tiedSel = 1'b0;
  logic          rdClk;
  logic          rstN = 1'b1;
  logic          wrEnN = 1'b1;
  logic          rdEnN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          fullN, almostFullN, emptyN, almostEmptyN;

  int            checks = 0;
  int            errors = 0;
  bit            live = 1'b0;
  bit            done = 1'b0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] expOut = '0;

  always #2.5 wrClk = ~wrClk;
  initial begin
    #1.1;
    forever #3.65 rdFree = ~rdFree;
  end
  assign rdClk = tiedSel ? wrClk : rdFree;

  xclk_fifo u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .wrData(wrData), .rdEnN(rdEnN), .rdData(rdData),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Write-side model: accept exactly when the DUT allowed it (R1), flags never optimistic (R8)
  always @(posedge wrClk) begin
    if (live) begin
      if (q.size() >= DEPTH)
        chk(fullN == 1'b0, "R8 fullN at full", int'(fullN), 0);
      if (q.size() >= DEPTH - 7)
        chk(almostFullN == 1'b0, "R8 almostFullN at threshold", int'(almostFullN), 0);
      if (!wrEnN && fullN) q.push_back(wrData);
    end
  end

  // Read-side model: pop when the DUT allowed it (R2), flags never optimistic (R8)
  always @(posedge rdClk) begin
    if (live) begin
      if (q.size() == 0)
        chk(emptyN == 1'b0, "R8 emptyN at empty", int'(emptyN), 0);
      if (q.size() < 8)
        chk(almostEmptyN == 1'b0, "R8 almostEmptyN at threshold", int'(almostEmptyN), 0);
      if (!rdEnN && emptyN && q.size() > 0) expOut = q.pop_front();
    end
  end

  always @(negedge rdClk) begin
    if (live) chk(rdData == expOut, "R1 R2 output word", int'(rdData), int'(expOut));
  end

  task automatic settle_check(input string tag);
    int n;
    @(negedge wrClk) wrEnN = 1'b1;
    @(negedge rdClk) rdEnN = 1'b1;
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
    n = q.size();
    chk(fullN == (n != DEPTH), {"R4 fullN ", tag}, int'(fullN), int'(n != DEPTH));
    chk(emptyN == (n != 0), {"R5 emptyN ", tag}, int'(emptyN), int'(n != 0));
    chk(almostEmptyN == (n >= 8), {"R6 almostEmptyN ", tag}, int'(almostEmptyN), int'(n >= 8));
    chk(almostFullN == (n < DEPTH - 7), {"R7 almostFullN ", tag}, int'(almostFullN),
        int'(n < DEPTH - 7));
  endtask

  task automatic fill_to(input int target);
    forever begin
      @(negedge wrClk);
      if (q.size() >= target) begin
        wrEnN = 1'b1;
        break;
      end
      wrEnN  = 1'b0;
      wrData = DW'($urandom);
    end
    settle_check($sformatf("at %0d words", target));
  endtask

  task automatic drain_to(input int target);
    forever begin
      @(negedge rdClk);
      if (q.size() <= target) begin
        rdEnN = 1'b1;
        break;
      end
      rdEnN = 1'b0;
    end
    settle_check($sformatf("at %0d words", target));
  endtask

  task automatic do_reset(input bit tied);
    live  = 1'b0;
    wrEnN = 1'b1;
    rdEnN = 1'b1;
    rstN  = 1'b0;
    #20;
    tiedSel = tied;
    #20;
    // R3: reset state
    chk(fullN == 1'b1, "R3 fullN in reset", int'(fullN), 1);
    chk(almostFullN == 1'b1, "R3 almostFullN in reset", int'(almostFullN), 1);
    chk(emptyN == 1'b0, "R3 emptyN in reset", int'(emptyN), 0);
    chk(almostEmptyN == 1'b0, "R3 almostEmptyN in reset", int'(almostEmptyN), 0);
    chk(rdData == '0, "R3 rdData in reset", int'(rdData), 0);
    @(negedge wrClk) rstN = 1'b1;
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
    q.delete();
    expOut = '0;
    live = 1'b1;
    settle_check("after reset R3");
  endtask

  task automatic traffic(input int n, input int wrPct, input int rdPct);
    fork
      repeat (n) begin
        @(negedge wrClk);
        wrEnN  = (($urandom % 100) >= wrPct);
        wrData = DW'($urandom);
      end
      repeat (n) begin
        @(negedge rdClk);
        rdEnN = (($urandom % 100) >= rdPct);
      end
    join
    settle_check("after traffic");
  endtask

  task automatic threshold_walk();
    logic [DW-1:0] held;
    fill_to(1);  fill_to(7);  fill_to(8);  fill_to(56);
    fill_to(57); fill_to(63); fill_to(64);
    // R4: writes while full are dropped; the count stays at DEPTH
    repeat (20) begin
      @(negedge wrClk);
      wrEnN  = 1'b0;
      wrData = DW'($urandom);
    end
    settle_check("R4 after writes while full");
    chk(q.size() == DEPTH, "R4 model count held", q.size(), DEPTH);
    drain_to(57); drain_to(56); drain_to(8); drain_to(7); drain_to(1); drain_to(0);
    // R5: reads while empty leave rdData unchanged
    held = rdData;
    repeat (20) begin
      @(negedge rdClk);
      rdEnN = 1'b0;
    end
    @(negedge rdClk) rdEnN = 1'b1;
    chk(rdData == held, "R5 rdData after reads while empty", int'(rdData), int'(held));
    settle_check("R5 after reads while empty");
  endtask

  initial begin
    do_reset(1'b0);
    threshold_walk();
    traffic(3000, 60, 45);
    traffic(3000, 40, 70);
    drain_to(0);
    fill_to(30);
    // R3: reset with data held and a non-zero output word
    do_reset(1'b1);
    // R9: tied clocks
    threshold_walk();
    traffic(3000, 55, 55);
    traffic(2000, 70, 30);
    drain_to(0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule